// File: doc/BRIEF.md
# Dual Asynchronous Transmit Queue Loader

This block is the host-facing front end of two transmit packet queues. One queue holds request packets and the other holds response packets. The host writes 32-bit quadlets through a simple write strobe with a byte address. Four word addresses are decoded, two for each queue. One address appends a quadlet that does not end the packet. The other appends the quadlet that closes the packet. The packet boundary therefore comes from which address the host writes, and no length field is involved.

Each accepted write goes first into a one-entry holding register for its queue. From there it is committed into that queue's FIFO on the next cycle, or later if the FIFO is full. Each FIFO entry carries an end-of-packet tag bit. Each queue has a write-ready flag for the host. The flag falls after every accepted write and comes back only once the held quadlet is actually inside the FIFO.

A write that arrives while the flag is low is thrown away, and a sticky overrun bit records the loss. A per-queue counter tracks how many complete packets sit in the FIFO. The downstream transmitter reads each queue through a head word, an empty flag and a pop strobe.

Top module: `txq_loader`

## Requirements
- R1: After reset both FIFOs are empty, both write-ready flags are 1, both overrun bits are 0 and both packet counters are 0.
- R2: With BASE = 0x88, byte address BASE+0x0 appends a non-final request quadlet, BASE+0x4 a final request quadlet, BASE+0x8 a non-final response quadlet and BASE+0xC a final response quadlet. A write to any other address changes no output.
- R3: Each stored entry holds the written quadlet and an end-of-packet tag. The tag is 1 exactly when the quadlet came through a final-quadlet address.
- R4: An accepted write drops that queue's ready flag on the next clock edge. When the FIFO has space, the quadlet is stored and the flag returns one edge later, so the flag is low for exactly one cycle.
- R5: If the FIFO is full, the flag stays low until the consumer pops an entry. The held quadlet is stored on that same edge, and the flag returns.
- R6: A write to a queue whose ready flag is low is dropped, leaving that queue's contents unchanged, and sets that queue's overrun bit. The overrun bit stays set until reset.
- R7: The request and response queues are independent: a write or pop on one never changes the other's outputs.
- R8: A queue's packet counter increments when a tagged quadlet is stored and decrements when a tagged entry is popped. When both happen on the same edge, the counter is unchanged.
- R9: A pop on an empty queue is ignored.
- R10: Each FIFO is first-in first-out. While not empty, its head outputs show the oldest entry, and a pop advances to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host byte address |
| wr_data | input | 32 | Host write quadlet |
| req_ready | output | 1 | Request queue write-ready flag |
| rsp_ready | output | 1 | Response queue write-ready flag |
| req_overrun | output | 1 | Sticky dropped-write flag, request queue |
| rsp_overrun | output | 1 | Sticky dropped-write flag, response queue |
| req_pkt_cnt | output | clog2(DEPTH+1) | Complete request packets in FIFO |
| rsp_pkt_cnt | output | clog2(DEPTH+1) | Complete response packets in FIFO |
| req_pop | input | 1 | Consumer pop, request queue |
| req_empty | output | 1 | Request FIFO empty |
| req_quad | output | 32 | Request FIFO head quadlet |
| req_eop | output | 1 | Request FIFO head end-of-packet tag |
| rsp_pop | input | 1 | Consumer pop, response queue |
| rsp_empty | output | 1 | Response FIFO empty |
| rsp_quad | output | 32 | Response FIFO head quadlet |
| rsp_eop | output | 1 | Response FIFO head end-of-packet tag |

## Verification
The bench targets the full-FIFO stall. A design that commits while full would overwrite the oldest entry. A design that raises the flag early would let a second write through.

It also targets back-to-back writes in the one cycle the flag is low. A design that stores such a write corrupts the packet, and one that ignores it without marking overrun hides the loss.

Pop and tagged push on the same edge are exercised, along with pops on an empty queue. A wrong counter there drifts or wraps.

Near-miss addresses are written to show that a loose decoder would put stray data into a queue.

// File: rtl/txq_pkg.sv
// Shared types for the transmit queue loader.
// Assumes 32-bit quadlets; queue index 0 is requests and 1 is responses.
package txq_pkg;
    localparam int QUAD_W = 32;
    localparam int N_Q    = 2;

    typedef struct packed {
        logic              eop;
        logic [QUAD_W-1:0] quad;
    } txq_entry_t;
endpackage

// File: rtl/txq_addr_dec.sv
// Host address decoder: turns a write strobe and byte address into one
// strobe per queue plus a final-quadlet flag.
// Assumes queue q owns BASE+8q (non-final) and BASE+8q+4 (final).
module txq_addr_dec
    import txq_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 8'h88
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [N_Q-1:0]    q_stb,
    output logic [N_Q-1:0]    q_last
);
    // Compare the address against both word addresses of each queue.
    always_comb begin
        for (int q = 0; q < N_Q; q++) begin
            q_stb[q]  = 1'b0;
            q_last[q] = 1'b0;
            if (wr_en && wr_addr == BASE + ADDR_W'(8 * q)) begin
                q_stb[q] = 1'b1;
            end
            if (wr_en && wr_addr == BASE + ADDR_W'(8 * q + 4)) begin
                q_stb[q]  = 1'b1;
                q_last[q] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/txq_fifo.sv
// Synchronous FIFO of tagged entries with a registered count.
// Assumes the caller never pushes while full unless it pops in the same
// cycle; a pop while empty is ignored.
module txq_fifo
    import txq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  txq_entry_t push_data,
    input  logic       pop,
    output txq_entry_t head,
    output logic       empty,
    output logic       full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    txq_entry_t     mem [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  count;
    logic           do_pop;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty  = (count == '0);
    assign full   = (count == CW'(DEPTH));
    assign do_pop = pop && !empty;
    assign head   = mem[rd_ptr];

    // Storage array write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop) rd_ptr <= ptr_inc(rd_ptr);
            case ({push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/txq_channel.sv
// One transmit queue: holding register, write-ready flag, sticky overrun,
// complete-packet counter and the FIFO behind them.
// Assumes wr_stb is a single-cycle decoded strobe for this queue.
module txq_channel
    import txq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_stb,
    input  logic                        wr_last,
    input  logic [QUAD_W-1:0]           wr_data,
    input  logic                        pop,
    output logic                        ready,
    output logic                        overrun,
    output logic [$clog2(DEPTH+1)-1:0]  pkt_cnt,
    output txq_entry_t                  head,
    output logic                        empty
);
    txq_entry_t hold_q;
    logic       hold_v;
    logic       full, accept, commit, pop_eff;

    assign ready   = !hold_v;
    assign accept  = wr_stb && !hold_v;
    assign pop_eff = pop && !empty;
    assign commit  = hold_v && (!full || pop_eff);

    // Capture an accepted quadlet and release it once committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold_q <= '0;
        end else if (accept) begin
            hold_v      <= 1'b1;
            hold_q.quad <= wr_data;
            hold_q.eop  <= wr_last;
        end else if (commit) begin
            hold_v <= 1'b0;
        end
    end

    // Record any write that arrives while the holding register is busy.
    always_ff @(posedge clk) begin
        if (!rst_n)                overrun <= 1'b0;
        else if (wr_stb && hold_v) overrun <= 1'b1;
    end

    // Count complete packets: tagged pushes in, tagged pops out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_cnt <= '0;
        end else begin
            case ({commit && hold_q.eop, pop_eff && head.eop})
                2'b10:   pkt_cnt <= pkt_cnt + 1'b1;
                2'b01:   pkt_cnt <= pkt_cnt - 1'b1;
                default: pkt_cnt <= pkt_cnt;
            endcase
        end
    end

    txq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (commit),
        .push_data (hold_q),
        .pop       (pop),
        .head      (head),
        .empty     (empty),
        .full      (full)
    );
endmodule

// File: rtl/txq_loader.sv
// Top: decodes host writes into a request and a response transmit queue.
// Assumes a single host writer and one consumer per queue.
module txq_loader
    import txq_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 8'h88,
    parameter int                DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [31:0]                wr_data,
    output logic                       req_ready,
    output logic                       rsp_ready,
    output logic                       req_overrun,
    output logic                       rsp_overrun,
    output logic [$clog2(DEPTH+1)-1:0] req_pkt_cnt,
    output logic [$clog2(DEPTH+1)-1:0] rsp_pkt_cnt,
    input  logic                       req_pop,
    output logic                       req_empty,
    output logic [31:0]                req_quad,
    output logic                       req_eop,
    input  logic                       rsp_pop,
    output logic                       rsp_empty,
    output logic [31:0]                rsp_quad,
    output logic                       rsp_eop
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [N_Q-1:0] q_stb, q_last, q_pop, q_ready, q_ovr, q_empty;
    logic [CW-1:0]  q_cnt [N_Q];
    txq_entry_t     q_head [N_Q];

    txq_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .q_stb   (q_stb),
        .q_last  (q_last)
    );

    assign q_pop = {rsp_pop, req_pop};

    for (genvar q = 0; q < N_Q; q++) begin : g_q
        txq_channel #(.DEPTH(DEPTH)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (q_stb[q]),
            .wr_last (q_last[q]),
            .wr_data (wr_data),
            .pop     (q_pop[q]),
            .ready   (q_ready[q]),
            .overrun (q_ovr[q]),
            .pkt_cnt (q_cnt[q]),
            .head    (q_head[q]),
            .empty   (q_empty[q])
        );
    end

    assign req_ready   = q_ready[0];
    assign rsp_ready   = q_ready[1];
    assign req_overrun = q_ovr[0];
    assign rsp_overrun = q_ovr[1];
    assign req_pkt_cnt = q_cnt[0];
    assign rsp_pkt_cnt = q_cnt[1];
    assign req_empty   = q_empty[0];
    assign rsp_empty   = q_empty[1];
    assign req_quad    = q_head[0].quad;
    assign req_eop     = q_head[0].eop;
    assign rsp_quad    = q_head[1].quad;
    assign rsp_eop     = q_head[1].eop;
endmodule

// File: rtl/txq_loader_chk.sv
// Protocol checker for txq_loader, attached by bind; observes ports only.
module txq_loader_chk #(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 8'h88,
    parameter int                DEPTH  = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic                       req_ready,
    input logic                       rsp_ready,
    input logic                       req_overrun,
    input logic                       rsp_overrun,
    input logic [$clog2(DEPTH+1)-1:0] req_pkt_cnt,
    input logic [$clog2(DEPTH+1)-1:0] rsp_pkt_cnt,
    input logic                       req_empty,
    input logic                       rsp_empty
);
    logic req_wr, rsp_wr;

    // Host writes aimed at each queue, derived independently of the decoder.
    assign req_wr = wr_en && (wr_addr == BASE || wr_addr == BASE + ADDR_W'(4));
    assign rsp_wr = wr_en && (wr_addr == BASE + ADDR_W'(8) || wr_addr == BASE + ADDR_W'(12));

    AST_REQ_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_ready) |=> !req_ready); // R4
    AST_RSP_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_wr && rsp_ready) |=> !rsp_ready); // R4
    AST_REQ_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !req_ready) |=> req_overrun); // R6
    AST_RSP_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_wr && !rsp_ready) |=> rsp_overrun); // R6
    AST_REQ_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        req_overrun |=> req_overrun); // R6
    AST_RSP_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_overrun |=> rsp_overrun); // R6
    AST_REQ_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_wr && req_ready) |=> req_ready); // R7
    AST_RSP_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_wr && rsp_ready) |=> rsp_ready); // R7
    AST_REQ_EMPTY_NO_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        req_empty |-> (req_pkt_cnt == '0)); // R8
    AST_RSP_EMPTY_NO_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_empty |-> (rsp_pkt_cnt == '0)); // R8
endmodule

bind txq_loader txq_loader_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .req_ready   (req_ready),
    .rsp_ready   (rsp_ready),
    .req_overrun (req_overrun),
    .rsp_overrun (rsp_overrun),
    .req_pkt_cnt (req_pkt_cnt),
    .rsp_pkt_cnt (rsp_pkt_cnt),
    .req_empty   (req_empty),
    .rsp_empty   (rsp_empty)
);

// File: tb/test_txq_loader.sv
module test_txq_loader;
    localparam int AW    = 8;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] BASE = 8'h88;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          req_pop = 1'b0, rsp_pop = 1'b0;
    logic          req_ready, rsp_ready, req_overrun, rsp_overrun;
    logic [CW-1:0] req_pkt_cnt, rsp_pkt_cnt;
    logic          req_empty, rsp_empty, req_eop, rsp_eop;
    logic [31:0]   req_quad, rsp_quad;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    // Reference model of both queues.
    logic [32:0] m_mem [2][DEPTH];
    int          m_rd [2], m_n [2], m_cnt [2];
    bit          m_hv [2], m_ovr [2];
    logic [32:0] m_hold [2];

    always #10 clk = ~clk;

    txq_loader #(.ADDR_W(AW), .BASE(BASE), .DEPTH(DEPTH)) i_txq_loader (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .req_ready(req_ready), .rsp_ready(rsp_ready),
        .req_overrun(req_overrun), .rsp_overrun(rsp_overrun),
        .req_pkt_cnt(req_pkt_cnt), .rsp_pkt_cnt(rsp_pkt_cnt),
        .req_pop(req_pop), .req_empty(req_empty), .req_quad(req_quad), .req_eop(req_eop),
        .rsp_pop(rsp_pop), .rsp_empty(rsp_empty), .rsp_quad(rsp_quad), .rsp_eop(rsp_eop)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected queue index and final flag for a host address (-1: no queue).
    function automatic int addr_q(input logic [AW-1:0] a);
        for (int q = 0; q < 2; q++)
            if (a == BASE + AW'(8 * q) || a == BASE + AW'(8 * q + 4)) return q;
        return -1;
    endfunction

    function automatic bit addr_last(input logic [AW-1:0] a);
        return (a == BASE + AW'(4)) || (a == BASE + AW'(12));
    endfunction

    task automatic model_reset();
        for (int q = 0; q < 2; q++) begin
            m_rd[q] = 0; m_n[q] = 0; m_cnt[q] = 0; m_hv[q] = 0; m_ovr[q] = 0; m_hold[q] = '0;
        end
    endtask

    task automatic model_edge();
        int  wq;
        bit  pop, pe, push;
        wq = wr_en ? addr_q(wr_addr) : -1;
        for (int q = 0; q < 2; q++) begin
            pop  = (q == 0) ? req_pop : rsp_pop;
            pe   = pop && (m_n[q] > 0);
            push = m_hv[q] && (m_n[q] < DEPTH || pe);
            if (pe) begin
                if (m_mem[q][m_rd[q]][32]) m_cnt[q]--;
                m_rd[q] = (m_rd[q] + 1) % DEPTH;
                m_n[q]--;
            end
            if (push) begin
                m_mem[q][(m_rd[q] + m_n[q]) % DEPTH] = m_hold[q];
                if (m_hold[q][32]) m_cnt[q]++;
                m_n[q]++;
                m_hv[q] = 0;
            end else if (wq == q) begin
                if (!m_hv[q]) begin
                    m_hv[q] = 1;
                    m_hold[q] = {addr_last(wr_addr), wr_data};
                end else begin
                    m_ovr[q] = 1;
                end
            end else if (wq == q && m_hv[q]) begin
                m_ovr[q] = 1;
            end
            if (push && wq == q) m_ovr[q] = 1;
        end
    endtask

    task automatic compare_all();
        chk("R4 req_ready", 64'(req_ready), 64'(!m_hv[0]));
        chk("R4 rsp_ready", 64'(rsp_ready), 64'(!m_hv[1]));
        chk("R10 req_empty", 64'(req_empty), 64'(m_n[0] == 0));
        chk("R10 rsp_empty", 64'(rsp_empty), 64'(m_n[1] == 0));
        if (m_n[0] > 0) chk("R3 req head", {31'b0, req_eop, req_quad}, 64'(m_mem[0][m_rd[0]]));
        if (m_n[1] > 0) chk("R3 rsp head", {31'b0, rsp_eop, rsp_quad}, 64'(m_mem[1][m_rd[1]]));
        chk("R6 req_overrun", 64'(req_overrun), 64'(m_ovr[0]));
        chk("R6 rsp_overrun", 64'(rsp_overrun), 64'(m_ovr[1]));
        chk("R8 req_pkt_cnt", 64'(req_pkt_cnt), 64'(m_cnt[0]));
        chk("R8 rsp_pkt_cnt", 64'(rsp_pkt_cnt), 64'(m_cnt[1]));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic drive(input bit en, input logic [AW-1:0] a, input logic [31:0] d,
                         input bit p0, input bit p1);
        wr_en = en; wr_addr = a; wr_data = d; req_pop = p0; rsp_pop = p1;
    endtask

    task automatic idle();
        drive(0, '0, '0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state.
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 rsp_ready", 64'(rsp_ready), 64'd1);
        chk("R1 empties", {62'b0, req_empty, rsp_empty}, 64'd3);
        chk("R1 overruns", {62'b0, req_overrun, rsp_overrun}, 64'd0);
        chk("R1 counters", {req_pkt_cnt, rsp_pkt_cnt}, 64'd0);

        // R2: near-miss addresses leave both queues untouched.
        drive(1, BASE + 8'h10, 32'hDEAD0001, 0, 0); cyc();
        drive(1, BASE + 8'h02, 32'hDEAD0002, 0, 0); cyc();
        drive(1, BASE - 8'h04, 32'hDEAD0003, 0, 0); cyc();
        idle(); cyc();
        chk("R2 stray writes ignored", {60'b0, req_ready, rsp_ready, req_empty, rsp_empty}, 64'hF);

        // R3/R4: non-final then final quadlet, flag low exactly one cycle.
        drive(1, BASE, 32'hA1A1A1A1, 0, 0); cyc();
        idle();
        chk("R4 ready low after write", 64'(req_ready), 64'd0);
        cyc();
        chk("R4 ready back after commit", 64'(req_ready), 64'd1);
        drive(1, BASE + 8'h4, 32'hB2B2B2B2, 0, 0); cyc();
        idle(); cyc();
        chk("R3 head non-final", {31'b0, req_eop, req_quad}, {31'b0, 1'b0, 32'hA1A1A1A1});
        chk("R8 one packet", 64'(req_pkt_cnt), 64'd1);
        chk("R7 rsp untouched", {62'b0, rsp_empty, rsp_ready}, 64'd3);
        drive(0, '0, '0, 1, 0); cyc(); idle(); cyc();
        chk("R10 head advanced", {31'b0, req_eop, req_quad}, {31'b0, 1'b1, 32'hB2B2B2B2});
        drive(0, '0, '0, 1, 0); cyc(); idle(); cyc();

        // R5: fill response FIFO, extra write stalls until a pop.
        for (int i = 0; i < DEPTH; i++) begin
            drive(1, BASE + 8'hC, 32'hC0000000 + 32'(i), 0, 0); cyc();
            idle(); cyc();
        end
        drive(1, BASE + 8'h8, 32'hC0FFEE00, 0, 0); cyc();
        idle();
        repeat (3) cyc();
        chk("R5 ready held low while full", 64'(rsp_ready), 64'd0);
        drive(0, '0, '0, 0, 1); cyc();
        idle();
        chk("R5 ready back after pop", 64'(rsp_ready), 64'd1);
        cyc();

        // R6: back-to-back write is dropped and flagged.
        drive(0, '0, '0, 0, 1);
        repeat (DEPTH) cyc();
        drive(1, BASE, 32'h11111111, 0, 0); cyc();
        drive(1, BASE, 32'h22222222, 0, 0); cyc();
        idle(); cyc();
        chk("R6 req overrun set", 64'(req_overrun), 64'd1);
        chk("R6 dropped write not stored", {31'b0, req_eop, req_quad}, {31'b0, 1'b0, 32'h11111111});

        // R9: pops on empty response queue do nothing.
        drive(0, '0, '0, 0, 1); repeat (3) cyc();
        idle(); cyc();
        chk("R9 empty pop ignored", {61'b0, rsp_empty, rsp_pkt_cnt == '0, rsp_ready}, 64'd7);

        // Constrained random traffic.
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a;
            int r;
            r = $urandom_range(0, 9);
            a = (r < 8) ? BASE + AW'(4 * (r % 4)) : AW'($urandom);
            drive($urandom_range(0, 2) != 0, a, $urandom, $urandom_range(0, 2) == 0,
                  $urandom_range(0, 2) == 0);
            cyc();
        end
        drive(0, '0, '0, 1, 1);
        repeat (2 * DEPTH + 4) cyc();
        idle(); cyc();
        chk("R8 drained counters", {req_pkt_cnt, rsp_pkt_cnt}, 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule